// File: doc/BRIEF.md
# Radio Event Interrupt and Fault Status Controller

This block sits between a radio datapath and the host. It takes single-cycle event pulses from the datapath: packet received, transmit finished, CRC error, acknowledgment timeout, FIFO overflow, FIFO underflow and channel busy. It also takes a qualified RSSI sample. Each source is held as a sticky status flag. Software reads all flags from one status register and clears chosen flags by writing ones to them. A mask register keeps chosen sources off the host interrupt line. Masked sources still latch their flags, so polling software can see them.

The RSSI source is filtered. A sample raises its flag only when it is strictly above a programmable threshold. The interrupt line is a one-cycle pulse, given when an unmasked flag newly sets. A flag that stays set therefore never re-raises the line. A saturating counter tracks consecutive error events, and software can read it to decide whether to move channel or slow the link. The register port is a plain write strobe with a combinational read mux. There is no data stream and no back-pressure anywhere at the edge of the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status flags are all 0, the mask is all ones (every source suppressed), the RSSI threshold is all ones, the error count is 0 and `irq` is low.
- R2: An event pulse sets its status flag at the next rising clock edge. Status bit layout: 0 packet received, 1 transmit done, 2 CRC error, 3 ack timeout, 4 FIFO overflow, 5 FIFO underflow, 6 channel busy, 7 RSSI above threshold. `evt_pulse[6:0]` drives bits 6..0.
- R3: A flag stays set until a write to address 0 carries a 1 in its bit position. Bits written as 0 leave their flags unchanged.
- R4: The mask register is at address 1. A mask bit of 1 keeps that source off `irq`, but its flag still latches.
- R5: `irq` is high for exactly one cycle, starting at the edge where an unmasked flag goes from 0 to 1. Unmasking a flag that is already set gives no pulse.
- R6: An event on a flag that is already set gives no pulse. Several flags newly set in the same cycle give a single one-cycle pulse.
- R7: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: The RSSI flag (bit 7) sets only when `rssi_valid` is high and `rssi_sample` is strictly greater than the threshold. The threshold is at address 2 and holds the low RSSI_W bits of the write. A sample equal to the threshold, or a sample without `rssi_valid`, does nothing.
- R9: The error count is read at address 3. It rises by one in every cycle that has at least one error event (bits 2..6). It returns to 0 in any cycle that has a packet-received or transmit-done event, and this return to 0 wins over a same-cycle error.
- R10: The error count saturates at 2^CNT_W-1.
- R11: Writes to address 3 change neither the error count nor any other register.
- R12: `reg_rdata` shows the register at `reg_addr` in the same cycle, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_pulse | input | 7 | Single-cycle event pulses, bit n sets status bit n |
| rssi_valid | input | 1 | RSSI sample qualifier |
| rssi_sample | input | RSSI_W | RSSI sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 mask, 2 threshold, 3 error count) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | One-cycle interrupt pulse to the host |

## Verification
The bench builds the block with RSSI_W=8 and CNT_W=4. The narrow counter lets the test reach saturation at 15 after a short run of error cycles, and it also exercises the zero-extension of the count on the read port. The full 8-bit RSSI width lets the comparison boundary be tested at a threshold of 100, with samples of 100 and 101. Interrupt pulses are counted at every falling edge, so a pulse that lasts too long, or a pulse that repeats, shows up as a count mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC   = 8;
  localparam int unsigned NUM_PULSE = 7;
  localparam int unsigned REG_W     = 8;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_THRESH = 2'd2,
    A_ERRCNT = 2'd3
  } addr_e;

  // sources that count as faults, and sources that reset the fault run
  localparam logic [NUM_SRC-1:0] ERR_SET = 8'b0111_1100;
  localparam logic [NUM_SRC-1:0] OK_SET  = 8'b0000_0011;
endpackage

// File: rtl/irq_rssi_cmp.sv
module irq_rssi_cmp #(
  parameter int unsigned RSSI_W = 8
) (
  input  logic              sample_valid,
  input  logic [RSSI_W-1:0] sample,
  input  logic [RSSI_W-1:0] thresh,
  output logic              hit
);
  assign hit = sample_valid && (sample > thresh);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] fresh;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status_o[i] <= 1'b0;
      else if (set_i[i]) status_o[i] <= 1'b1;
      else if (clr_i[i]) status_o[i] <= 1'b0;
    end
  end

  // only a 0->1 transition on an unmasked flag produces a pulse
  assign fresh = set_i & ~status_o & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |fresh;
  end
endmodule

// File: rtl/irq_err_counter.sv
module irq_err_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           count_o <= '0;
    else if (ok_i)                        count_o <= '0;
    else if (err_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned RSSI_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PULSE-1:0] evt_pulse,
  input  logic                 rssi_valid,
  input  logic [RSSI_W-1:0]    rssi_sample,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);
  logic [NUM_SRC-1:0] status_q, mask_q, set_vec, clr_vec;
  logic [RSSI_W-1:0]  thresh_q;
  logic [CNT_W-1:0]   err_cnt;
  logic               rssi_hit, wr_status, wr_mask, wr_thresh;
  addr_e              addr;

  assign addr      = addr_e'(reg_addr);
  assign wr_status = reg_wr && (addr == A_STATUS);
  assign wr_mask   = reg_wr && (addr == A_MASK);
  assign wr_thresh = reg_wr && (addr == A_THRESH);

  irq_rssi_cmp #(.RSSI_W(RSSI_W)) u_cmp (
    .sample_valid (rssi_valid),
    .sample       (rssi_sample),
    .thresh       (thresh_q),
    .hit          (rssi_hit)
  );

  assign set_vec = {rssi_hit, evt_pulse};
  assign clr_vec = wr_status ? reg_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      thresh_q <= '1;
    end else begin
      if (wr_mask)   mask_q   <= reg_wdata[NUM_SRC-1:0];
      if (wr_thresh) thresh_q <= reg_wdata[RSSI_W-1:0];
    end
  end

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .mask_i   (mask_q),
    .status_o (status_q),
    .irq_o    (irq)
  );

  irq_err_counter #(.CNT_W(CNT_W)) u_errcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_i   (|(set_vec & ERR_SET)),
    .ok_i    (|(set_vec & OK_SET)),
    .count_o (err_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    case (addr)
      A_STATUS: reg_rdata[NUM_SRC-1:0] = status_q;
      A_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
      A_THRESH: reg_rdata[RSSI_W-1:0]  = thresh_q;
      A_ERRCNT: reg_rdata[CNT_W-1:0]   = err_cnt;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned RSSI_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        evt_pulse,
  input logic              rssi_valid,
  input logic [RSSI_W-1:0] rssi_sample,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              irq,
  input logic [7:0]        status_q,
  input logic [7:0]        mask_q,
  input logic [RSSI_W-1:0] thresh_q,
  input logic [CNT_W-1:0]  err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]       status_prev, mask_prev, clr_prev;
  logic [CNT_W-1:0] cnt_prev;
  logic             hit_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_prev <= '0;
      mask_prev   <= '1;
      clr_prev    <= '0;
      cnt_prev    <= '0;
      hit_prev    <= 1'b0;
    end else begin
      status_prev <= status_q;
      mask_prev   <= mask_q;
      clr_prev    <= (reg_wr && reg_addr == 2'd0) ? reg_wdata : 8'h00;
      cnt_prev    <= err_cnt;
      hit_prev    <= rssi_valid && (rssi_sample > thresh_q);
    end
  end

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((status_q[6:0] & $past(evt_pulse)) == $past(evt_pulse))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_prev & ~status_q & ~clr_prev) == 8'h00)); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(status_q & ~status_prev & ~mask_prev))); // R5

  AST_RSSI_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rssi_valid && (rssi_sample > thresh_q)) |=> status_q[7]); // R8

  AST_RSSI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_prev[7] && status_q[7]) |-> hit_prev); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != cnt_prev) |-> (err_cnt == '0 || err_cnt == cnt_prev + 1'b1)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_prev == CNT_MAX) |-> (err_cnt == CNT_MAX || err_cnt == '0)); // R10
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.RSSI_W(RSSI_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_pulse   (evt_pulse),
  .rssi_valid  (rssi_valid),
  .rssi_sample (rssi_sample),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq         (irq),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .thresh_q    (thresh_q),
  .err_cnt     (err_cnt)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt_pulse = '0;
  logic       rssi_valid = 1'b0;
  logic [7:0] rssi_sample = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_status_ctrl #(.RSSI_W(8), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rssi_valid(rssi_valid),
    .rssi_sample(rssi_sample), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) if (irq === 1'b1) irq_seen++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] ev);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rssi(input logic v, input logic [7:0] s);
    rssi_valid = v; rssi_sample = s;
    @(negedge clk);
    rssi_valid = 1'b0; rssi_sample = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1", "status after reset", d, 8'h00);
    rd(2'd1, d); chk("R1", "mask after reset", d, 8'hFF);
    rd(2'd2, d); chk("R1", "threshold after reset", d, 8'hFF);
    rd(2'd3, d); chk("R1", "count after reset", d, 8'h00);
    chk("R1", "irq after reset", irq, 1'b0);
  endtask

  task automatic t_masked_latch();
    logic [7:0] d;
    int b = irq_seen;
    pulse(7'h04); idle(1);
    rd(2'd0, d); chk("R2", "crc flag latched", d, 8'h04);
    pulse(7'h7F); idle(1);
    rd(2'd0, d); chk("R2", "all seven flags latched", d, 8'h7F);
    chk("R4", "masked sources give no irq", irq_seen - b, 0);
    wr(2'd0, 8'h05);
    rd(2'd0, d); chk("R3", "w1c clears only written bits", d, 8'h7A);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R3", "zero write leaves flags", d, 8'h7A);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R3", "clear all", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    int b;
    wr(2'd1, 8'h00);
    b = irq_seen;
    pulse(7'h01);
    #1 chk("R5", "irq high after new flag", irq, 1'b1);
    idle(1);
    #1 chk("R5", "irq low one cycle later", irq, 1'b0);
    chk("R5", "one pulse cycle", irq_seen - b, 1);
    pulse(7'h01); idle(2);
    chk("R6", "repeat event on set flag no pulse", irq_seen - b, 1);
    pulse(7'h06); idle(2);
    chk("R6", "two new flags one pulse", irq_seen - b, 2);
    rd(2'd0, d); chk("R2", "status after irq test", d, 8'h07);
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_late_unmask();
    logic [7:0] d;
    int b;
    wr(2'd1, 8'hFF);
    b = irq_seen;
    pulse(7'h08);
    wr(2'd1, 8'h00); idle(2);
    chk("R5", "unmask of set flag gives no pulse", irq_seen - b, 0);
    rd(2'd0, d); chk("R4", "masked flag kept", d, 8'h08);
    wr(2'd1, 8'hEF);
    b = irq_seen;
    pulse(7'h20); idle(2);
    chk("R4", "masked underflow no irq", irq_seen - b, 0);
    pulse(7'h10); idle(2);
    chk("R4", "unmasked overflow irq", irq_seen - b, 1);
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_event_wins();
    logic [7:0] d;
    pulse(7'h04);
    evt_pulse = 7'h04; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h04;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, d); chk("R7", "event beats same-cycle clear", d, 8'h04);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R3", "plain clear afterwards", d, 8'h00);
  endtask

  task automatic t_rssi();
    logic [7:0] d;
    int b;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd100);
    rd(2'd2, d); chk("R12", "threshold readback", d, 8'd100);
    b = irq_seen;
    rssi(1'b0, 8'd200); idle(1);
    rd(2'd0, d); chk("R8", "invalid sample ignored", d, 8'h00);
    rssi(1'b1, 8'd100); idle(1);
    rd(2'd0, d); chk("R8", "equal sample ignored", d, 8'h00);
    rssi(1'b1, 8'd101); idle(1);
    rd(2'd0, d); chk("R8", "sample above threshold", d, 8'h80);
    chk("R8", "rssi irq pulse", irq_seen - b, 1);
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_errcnt();
    logic [7:0] d;
    pulse(7'h01);
    rd(2'd3, d); chk("R9", "success resets count", d, 8'd0);
    pulse(7'h04); pulse(7'h08); pulse(7'h40);
    rd(2'd3, d); chk("R9", "three error cycles", d, 8'd3);
    pulse(7'h30);
    rd(2'd3, d); chk("R9", "two errors one cycle count once", d, 8'd4);
    pulse(7'h02);
    rd(2'd3, d); chk("R9", "tx done resets count", d, 8'd0);
    for (int i = 0; i < 20; i++) pulse(7'h10);
    rd(2'd3, d); chk("R10", "count saturates", d, 8'd15);
    wr(2'd3, 8'hAA);
    rd(2'd3, d); chk("R11", "count write ignored", d, 8'd15);
    rd(2'd1, d); chk("R11", "mask untouched by count write", d, 8'h00);
    rd(2'd2, d); chk("R11", "threshold untouched by count write", d, 8'd100);
    pulse(7'h05);
    rd(2'd3, d); chk("R9", "success wins over error", d, 8'd0);
    wr(2'd0, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_masked_latch();
    t_irq();
    t_late_unmask();
    t_event_wins();
    t_rssi();
    t_errcnt();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule